// File: doc/BRIEF.md
# Dual-Port Word Memory with Same-Address Arbitration

This block is a synchronous memory that two independent agents, a left port and a right port, can read and write at the same time. Each port has its own address, chip enable, write strobe, output enable, two byte-lane enables and data buses. Both ports may reach any word in any cycle, including the same word. When both ports are enabled on one address, an arbiter decides which port was there first. The other port sees its BUSY flag, and a write from that port is dropped. A read from that port still goes ahead.

A mode input selects between master and slave use. A master drives its two BUSY outputs from its own arbiter. A slave holds its BUSY outputs low and takes the write-inhibit decision from two BUSY inputs instead. When several such memories are placed side by side to form a wider word, this lets a single master's arbitration govern every slice. The depth is a parameter. The default is kept small enough for elaboration, and the address width scales up to 64K words of 16 bits.

Top module: `dual_port_ram_arb`

## Requirements
- R1: A write (chip enable high, write strobe high) updates only the byte lanes whose enable is high: upper enable covers bits 15:8 and lower enable covers bits 7:0. The other lane keeps its stored value.
- R2: A read (chip enable high, write strobe low, output enable high) presents the addressed word on that port's read data one clock edge later. Lanes whose enable was low read as zero. A cycle without such a read gives zero on the next edge.
- R3: Both ports operate in the same cycle on different addresses without interfering, and neither BUSY output rises.
- R4: In master mode, when the two enabled ports come to share an address and one of them had already been enabled on that same address in the previous cycle, that earlier port wins. The other port's BUSY output goes high in that same cycle.
- R5: In master mode, when both ports arrive on a shared address in the same cycle, the left port wins and the right port's BUSY goes high.
- R6: While both ports stay enabled on the same unchanged address, the winner keeps winning and the loser's BUSY stays high.
- R7: BUSY is low in any cycle in which the ports do not share an address or either chip enable is low, and the two BUSY outputs are never high together.
- R8: A write from a port whose BUSY is high is dropped, and memory keeps the old word. A read from that port still returns data.
- R9: When the winning port writes and the losing port reads the same address in the same cycle, the reader receives the word as it stood before that write.
- R10: In slave mode (mode input low), both BUSY outputs are held low and the arbiter inhibits no write. A high BUSY input drops that port's write, and a low one lets it through.
- R11: While synchronous active-low reset is asserted, both BUSY outputs are low, and after a reset edge both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_sel | input | 1 | 1 = master (BUSY driven), 0 = slave (BUSY taken as input) |
| lft_ce | input | 1 | Left chip enable |
| lft_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| lft_oe | input | 1 | Left output enable |
| lft_ub | input | 1 | Left upper-lane enable (bits 15:8) |
| lft_lb | input | 1 | Left lower-lane enable (bits 7:0) |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left read data, one edge after the read |
| lft_busy_in | input | 1 | Left external write inhibit, used in slave mode |
| lft_busy_out | output | 1 | Left lost arbitration, master mode only |
| rgt_ce | input | 1 | Right chip enable |
| rgt_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| rgt_oe | input | 1 | Right output enable |
| rgt_ub | input | 1 | Right upper-lane enable (bits 15:8) |
| rgt_lb | input | 1 | Right lower-lane enable (bits 7:0) |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data, one edge after the read |
| rgt_busy_in | input | 1 | Right external write inhibit, used in slave mode |
| rgt_busy_out | output | 1 | Right lost arbitration, master mode only |

## Verification
The embedded properties check on every cycle that the two loss flags are never high together and never high without a shared address. They also check that a fresh tie goes to the left port, that a loser stays a loser while the shared address holds, that slave mode keeps BUSY quiet, and that disabled or idle reads return zero. What only the bench scenarios can show is the content of memory: dropped writes leave the old word, partial writes leave the other lane intact, a losing reader sees the pre-write word, and the winner chosen when one port was already in place. Each of these is confirmed by a later read through the ports.

// File: rtl/dpr_pkg.sv
// Package dpr_pkg
// Shared types for the dual-port arbitrated memory.
// Assumes two byte lanes per word; lane 1 is the upper lane.
package dpr_pkg;
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Per-port decoded access request inside the block
    typedef struct packed {
        logic       rd;     // read with output enabled
        logic       wr;     // write after inhibit
        logic [1:0] lanes;  // {upper, lower}
    } port_op_t;
endpackage

// File: rtl/dpr_arbiter.sv
// Module dpr_arbiter
// Detects both ports enabled on one address and picks the port that was
// present first (previous cycle, same address, enabled). A fresh tie goes
// to the left port. The winner is held while the shared address persists.
// Assumes synchronous inputs; loss flags are forced low during reset.
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              ce_r,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              lose_l,
    output logic              lose_r
);
    logic              pv_ce_l, pv_ce_r, pv_match;
    logic [ADDR_W-1:0] pv_addr_l, pv_addr_r;
    side_e             owner_q, owner_now;
    logic              match, stable_l, stable_r, fresh;

    // Decide the owner for this cycle from history and current inputs
    always_comb begin
        match    = ce_l && ce_r && (addr_l == addr_r);
        stable_l = pv_ce_l && (pv_addr_l == addr_l);
        stable_r = pv_ce_r && (pv_addr_r == addr_r);
        fresh    = match && !(pv_match && (pv_addr_l == addr_l));
        if (fresh)
            owner_now = (stable_r && !stable_l) ? SIDE_RIGHT : SIDE_LEFT;
        else
            owner_now = owner_q;
        lose_l = rst_n && match && (owner_now == SIDE_RIGHT);
        lose_r = rst_n && match && (owner_now == SIDE_LEFT);
    end

    // Remember last cycle's enables, addresses, match and owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_ce_l   <= 1'b0;
            pv_ce_r   <= 1'b0;
            pv_addr_l <= '0;
            pv_addr_r <= '0;
            pv_match  <= 1'b0;
            owner_q   <= SIDE_LEFT;
        end else begin
            pv_ce_l   <= ce_l;
            pv_ce_r   <= ce_r;
            pv_addr_l <= addr_l;
            pv_addr_r <= addr_r;
            pv_match  <= match;
            if (match)
                owner_q <= owner_now;
        end
    end

    // R7
    lose_never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lose_l && lose_r));

    // R7
    lose_needs_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_l && ce_r && addr_l == addr_r) |-> (!lose_l && !lose_r));

    // R5
    tie_goes_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_l && ce_r && addr_l == addr_r && !$past(ce_l) && !$past(ce_r))
        |-> lose_r);

    // R6
    loser_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_l && ce_r && addr_l == addr_r && addr_l == $past(addr_l)
         && $past(lose_r)) |-> lose_r);
endmodule

// File: rtl/dpr_lane_store.sv
// Module dpr_lane_store
// Storage split into byte lanes, one array per lane, each written by both
// ports. Reads are registered and read-before-write: a read in the same
// cycle as a write to the same word returns the older word. Disabled
// lanes and idle cycles give zero. Assumes the caller never lets both
// ports write one lane of one word in one cycle; if it does, right lands.
module dpr_lane_store
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_t          op_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  port_op_t          op_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r
);
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Write this lane from either port, then latch the read slice
        always_ff @(posedge clk) begin
            if (op_l.wr && op_l.lanes[g])
                cells[addr_l] <= wdata_l[g*LANE_W +: LANE_W];
            if (op_r.wr && op_r.lanes[g])
                cells[addr_r] <= wdata_r[g*LANE_W +: LANE_W];
        end

        // Registered read slice per port, zero when not requested
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_l[g*LANE_W +: LANE_W] <= '0;
                rdata_r[g*LANE_W +: LANE_W] <= '0;
            end else begin
                rdata_l[g*LANE_W +: LANE_W] <= (op_l.rd && op_l.lanes[g]) ?
                                               cells[addr_l] : '0;
                rdata_r[g*LANE_W +: LANE_W] <= (op_r.rd && op_r.lanes[g]) ?
                                               cells[addr_r] : '0;
            end
        end
    end
endmodule

// File: rtl/dual_port_ram_arb.sv
// Module dual_port_ram_arb
// Top of the dual-port memory. Decodes each port's strobes, applies the
// write inhibit (own arbiter in master mode, BUSY input in slave mode),
// and drives the push-pull BUSY outputs. Assumes all inputs are
// synchronous to clk; reset is synchronous and active low.
module dual_port_ram_arb
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              lft_ce,
    input  logic              lft_we,
    input  logic              lft_oe,
    input  logic              lft_ub,
    input  logic              lft_lb,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              lft_busy_in,
    output logic              lft_busy_out,
    input  logic              rgt_ce,
    input  logic              rgt_we,
    input  logic              rgt_oe,
    input  logic              rgt_ub,
    input  logic              rgt_lb,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata,
    input  logic              rgt_busy_in,
    output logic              rgt_busy_out
);
    localparam int HALF = DATA_W / 2;

    logic     lose_l, lose_r, inhibit_l, inhibit_r;
    port_op_t op_l, op_r;

    dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_l   (lft_ce),
        .addr_l (lft_addr),
        .ce_r   (rgt_ce),
        .addr_r (rgt_addr),
        .lose_l (lose_l),
        .lose_r (lose_r)
    );

    // Select the inhibit source by mode and decode each port's operation
    always_comb begin
        inhibit_l  = master_sel ? lose_l : lft_busy_in;
        inhibit_r  = master_sel ? lose_r : rgt_busy_in;
        op_l.rd    = lft_ce && !lft_we && lft_oe;
        op_l.wr    = lft_ce && lft_we && !inhibit_l;
        op_l.lanes = {lft_ub, lft_lb};
        op_r.rd    = rgt_ce && !rgt_we && rgt_oe;
        op_r.wr    = rgt_ce && rgt_we && !inhibit_r;
        op_r.lanes = {rgt_ub, rgt_lb};
    end

    // Push-pull BUSY outputs: arbiter result in master mode, low in slave
    assign lft_busy_out = master_sel && lose_l;
    assign rgt_busy_out = master_sel && lose_r;

    dpr_lane_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_l    (op_l),
        .addr_l  (lft_addr),
        .wdata_l (lft_wdata),
        .rdata_l (lft_rdata),
        .op_r    (op_r),
        .addr_r  (rgt_addr),
        .wdata_r (rgt_wdata),
        .rdata_r (rgt_rdata)
    );

    // R10
    slave_busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (!lft_busy_out && !rgt_busy_out));

    // R11
    reset_busy_low_chk: assert property (@(posedge clk)
        !rst_n |-> (!lft_busy_out && !rgt_busy_out));

    // R2
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lft_ce && !lft_we && lft_oe) |=> (lft_rdata == '0));

    // R2
    upper_lane_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_ce && !rgt_we && !rgt_ub) |=> (rgt_rdata[DATA_W-1:HALF] == '0));
endmodule

// File: tb/tb_dual_port_ram_arb.sv
module tb_dual_port_ram_arb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;

    typedef struct packed {
        logic [3:0]    req;
        logic          ms;
        logic          lc, lw, lo, lu, ll;
        logic [AW-1:0] la;
        logic [DW-1:0] ld;
        logic          rc, rw, ro, ru, rl;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        logic          bil, bir;
        logic          ebl, ebr;
        logic [DW-1:0] erl, err;
    } vec_t;

    localparam int NV = 21;
    // fields: req, ms, L{ce,we,oe,ub,lb,addr,wdata}, R{...}, busy_in l/r,
    //         expected busy l/r, expected rdata l/r (after this cycle's edge)
    localparam vec_t TBL [NV] = '{
        '{1, 1, 1,1,0,1,1,'h010,'h1234, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'h0000,'h0000}, // R1 full write
        '{3, 1, 1,1,0,1,1,'h011,'h5566, 1,1,0,1,1,'h020,'hABCD, 0,0, 0,0,'h0000,'h0000}, // R3 parallel writes
        '{2, 1, 1,0,1,1,1,'h010,'h0000, 1,0,1,1,1,'h020,'h0000, 0,0, 0,0,'h1234,'hABCD}, // R2 parallel reads
        '{1, 1, 1,1,0,1,0,'h010,'hFF00, 1,0,1,1,0,'h011,'h0000, 0,0, 0,0,'h0000,'h5500}, // R1 upper-only write, R2 lane mask
        '{4, 1, 1,0,0,1,1,'h010,'h0000, 1,0,1,0,1,'h010,'h0000, 0,0, 0,1,'h0000,'h0034}, // R4 left already there
        '{6, 1, 1,0,1,1,1,'h010,'h0000, 1,1,0,1,1,'h010,'h9999, 0,0, 0,1,'hFF34,'h0000}, // R6 held, R8 drop
        '{8, 1, 1,0,1,1,1,'h010,'h0000, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'hFF34,'h0000}, // R8 old word kept
        '{7, 1, 0,0,0,0,0,'h000,'h0000, 1,1,0,1,1,'h030,'h0F0F, 0,0, 0,0,'h0000,'h0000}, // R7 no share
        '{5, 1, 1,1,0,1,1,'h040,'h2222, 1,1,0,1,1,'h040,'h3333, 0,0, 0,1,'h0000,'h0000}, // R5 tie
        '{5, 1, 1,0,1,1,1,'h040,'h0000, 1,0,1,1,1,'h040,'h0000, 0,0, 0,1,'h2222,'h2222}, // R5 left landed
        '{7, 1, 0,0,0,0,0,'h000,'h0000, 1,0,1,1,1,'h030,'h0000, 0,0, 0,0,'h0000,'h0F0F}, // R7 ce low
        '{4, 1, 1,1,0,1,1,'h030,'h7777, 1,0,1,1,1,'h030,'h0000, 0,0, 1,0,'h0000,'h0F0F}, // R4 right already there
        '{7, 1, 0,0,0,0,0,'h000,'h0000, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'h0000,'h0000}, // R7 idle
        '{9, 1, 1,1,0,1,1,'h050,'h4444, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'h0000,'h0000}, // R9 setup
        '{9, 1, 1,1,0,1,1,'h050,'h5555, 1,0,1,1,1,'h050,'h0000, 0,0, 0,1,'h0000,'h4444}, // R9 old data
        '{9, 1, 1,0,1,1,1,'h050,'h0000, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'h5555,'h0000}, // R9 winner wrote
        '{8, 1, 0,0,0,0,0,'h000,'h0000, 1,0,1,1,1,'h030,'h0000, 0,0, 0,0,'h0000,'h0F0F}, // R8 loser write dropped
        '{10,0, 1,1,0,1,1,'h010,'h6060, 1,1,0,1,1,'h061,'h6161, 1,0, 0,0,'h0000,'h0000}, // R10 inhibit by input
        '{10,0, 1,0,1,1,1,'h010,'h0000, 1,0,1,1,1,'h061,'h0000, 0,0, 0,0,'hFF34,'h6161}, // R10 results
        '{10,0, 1,0,1,1,1,'h061,'h0000, 1,1,0,1,1,'h061,'h6262, 0,0, 0,0,'h6161,'h0000}, // R10 no internal inhibit
        '{10,0, 1,0,1,1,1,'h061,'h0000, 0,0,0,0,0,'h000,'h0000, 0,0, 0,0,'h6262,'h0000}  // R10 write landed
    };

    logic clk = 1'b0;
    logic rst_n, master_sel;
    logic lft_ce, lft_we, lft_oe, lft_ub, lft_lb, lft_busy_in, lft_busy_out;
    logic rgt_ce, rgt_we, rgt_oe, rgt_ub, rgt_lb, rgt_busy_in, rgt_busy_out;
    logic [AW-1:0] lft_addr, rgt_addr;
    logic [DW-1:0] lft_wdata, rgt_wdata, lft_rdata, rgt_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_ram_arb #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .lft_ce(lft_ce), .lft_we(lft_we), .lft_oe(lft_oe), .lft_ub(lft_ub),
        .lft_lb(lft_lb), .lft_addr(lft_addr), .lft_wdata(lft_wdata),
        .lft_rdata(lft_rdata), .lft_busy_in(lft_busy_in), .lft_busy_out(lft_busy_out),
        .rgt_ce(rgt_ce), .rgt_we(rgt_we), .rgt_oe(rgt_oe), .rgt_ub(rgt_ub),
        .rgt_lb(rgt_lb), .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata),
        .rgt_rdata(rgt_rdata), .rgt_busy_in(rgt_busy_in), .rgt_busy_out(rgt_busy_out)
    );

    task automatic check(input string what, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        master_sel = v.ms;
        lft_ce = v.lc; lft_we = v.lw; lft_oe = v.lo; lft_ub = v.lu; lft_lb = v.ll;
        lft_addr = v.la; lft_wdata = v.ld; lft_busy_in = v.bil;
        rgt_ce = v.rc; rgt_we = v.rw; rgt_oe = v.ro; rgt_ub = v.ru; rgt_lb = v.rl;
        rgt_addr = v.ra; rgt_wdata = v.rd; rgt_busy_in = v.bir;
    endtask

    localparam vec_t IDLE = '{0, 1, 0,0,0,0,0,'h000,'h0000, 0,0,0,0,0,'h000,'h0000,
                              0,0, 0,0,'h0000,'h0000};

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        rst_n = 1'b0;
        drive(IDLE);
        // R11: reset with both ports sharing an address keeps BUSY low
        v = IDLE; v.lc = 1; v.rc = 1; v.la = 'h005; v.ra = 'h005;
        drive(v);
        repeat (3) @(posedge clk);
        #1;
        check("R11 lft_busy_out in reset", {15'b0, lft_busy_out}, 16'h0);
        check("R11 rgt_busy_out in reset", {15'b0, rgt_busy_out}, 16'h0);
        check("R11 lft_rdata after reset", lft_rdata, 16'h0000);
        check("R11 rgt_rdata after reset", rgt_rdata, 16'h0000);
        @(negedge clk);
        drive(IDLE);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #1;
            check($sformatf("R%0d vec%0d lft_busy_out", TBL[i].req, i),
                  {15'b0, lft_busy_out}, {15'b0, TBL[i].ebl});
            check($sformatf("R%0d vec%0d rgt_busy_out", TBL[i].req, i),
                  {15'b0, rgt_busy_out}, {15'b0, TBL[i].ebr});
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d lft_rdata", TBL[i].req, i), lft_rdata, TBL[i].erl);
            check($sformatf("R%0d vec%0d rgt_rdata", TBL[i].req, i), rgt_rdata, TBL[i].err);
        end

        // R11: reset during a read clears the read data
        @(negedge clk);
        v = IDLE; v.lc = 1; v.lo = 1; v.lu = 1; v.ll = 1; v.la = 'h050;
        drive(v);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R11 lft_rdata on reset edge", lft_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R2: memory survives reset, read resumes
        check("R2 lft_rdata after reset release", lft_rdata, 16'h5555);

        // R2: lower lane only from the left port
        @(negedge clk);
        v.lu = 0;
        drive(v);
        @(posedge clk);
        #1;
        check("R2 lft_rdata lower lane only", lft_rdata, 16'h0055);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule